// File: doc/BRIEF.md
# Display PLL Divisor Search Engine

This block picks divider settings for a display clock synthesizer. A single start pulse hands it a requested pixel clock and the reference clock, both in kHz. The engine first picks a DAC oversampling multiplier from the pixel clock and scales the pixel clock by it to get the target dot clock. It then walks every combination of the pre-divider n, the two feedback divider stages m1 and m2, and the post-divider p1, in a fixed order. The second post-divider p2 is fixed at 10.

Each candidate is tested against a set of range rules. The feedback multiplier is M = 5*m1 + m2. The VCO frequency is ref*M/n and the dot clock is VCO/(10*p1). A candidate whose dot clock equals the target exactly ends the search at once. Otherwise the engine keeps the candidate that overshoots the target by the least. Candidates below the target never win.

Both divisions go through one shared restoring divider that resolves several quotient bits per cycle. The result is the chosen divider values, a found flag, the multiplier and a packed divider word. All of these are held until the next search completes.

Top module: `pll_search`

## Requirements
- R1: After reset, busy, done and found are 0. nOut, m1Out, m2Out, p1Out, dacMult and divWord are all 0.
- R2: The multiplier is set from pixKhz as follows:
  - 1 when pixKhz is 100000 or more.
  - 2 when pixKhz is 50000 or more.
  - 4 when pixKhz is 25000 or more.
  - The target is pixKhz times the multiplier.
  - When pixKhz is below 25000, done rises within 4 cycles of start with found = 0, dacMult = 0 and all divider outputs 0.
- R3: All arithmetic is in kHz with truncating division. VCO = floor(refKhz*M/n), with M = 5*m1 + m2. Dot clock = floor(VCO/(10*p1)).
- R4: A candidate is legal only if all of these hold:
  - n is in 3..8, m1 is in 10..20, m2 is in 5..9 and p1 is in 1..8.
  - m1 > m2.
  - M is in 70..120.
  - 10*p1 is in 5..80.
  - VCO is in 1400000..2800000.
  - The dot clock is in 20000..400000.
- R5: Candidates are visited in this nesting, outermost first:
  - n ascending.
  - m1 descending.
  - m2 descending.
  - p1 descending.
- R6: The first legal candidate whose dot clock equals the target ends the search. It is reported with found = 1.
- R7: Otherwise the result is the legal candidate with the smallest dot clock strictly above the target. Among candidates with equal error, the earliest visited wins.
- R8: If no legal candidate reaches or exceeds the target, found = 0 and nOut, m1Out, m2Out, p1Out and divWord are 0.
- R9: On found = 1, divWord is packed with these bit positions:
  - bits 7:0 hold m2-2.
  - bits 15:8 hold m1-2.
  - bits 23:16 hold n-2.
- R10: done is a one-cycle pulse in the cycle where busy falls. The result outputs change only in that cycle.
- R11: A start pulse while busy is high is ignored. The running search completes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a search when idle; pixKhz and refKhz are captured on it |
| pixKhz | input | 20 | Requested pixel clock in kHz |
| refKhz | input | 17 | Reference clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A setting was found |
| nOut | output | 4 | Chosen pre-divider n |
| m1Out | output | 5 | Chosen first feedback stage m1 |
| m2Out | output | 4 | Chosen second feedback stage m2 |
| p1Out | output | 4 | Chosen post-divider p1 |
| dacMult | output | 3 | DAC multiplier (1, 2, 4, or 0 below minimum) |
| divWord | output | 24 | Packed divider word |

## Verification
The outcome that is hardest to provoke from the ports is a tie-break inside the overshoot rule. Several legal candidates can land on the same truncated dot clock, and only the visiting order decides which one is reported. The stimulus covers this with a sweep of pixel clocks that exercises all three multiplier bands, including the threshold values. It adds a second reference clock and an exact hit. Each result is compared field by field against an arithmetic model of the whole search in the bench, which reproduces the kHz truncation and visiting order independently. A pixel clock just above the top dot clock limit drives the engine through the complete space with no winner.

// File: rtl/pll_search_pkg.sv
`timescale 1ns/1ps
package pll_search_pkg;
  localparam int PIX_W   = 20;
  localparam int REF_W   = 17;
  localparam int NUM_W   = 24;
  localparam int DEN_W   = 8;
  localparam int N_W     = 4;
  localparam int M1_W    = 5;
  localparam int M2_W    = 4;
  localparam int P1_W    = 4;
  localparam int M_W     = 7;
  localparam int MULT_W  = 3;
  localparam int FIELD_W = 8;
  localparam int WORD_W  = 3 * FIELD_W;

  localparam logic [N_W-1:0]   N_LO  = N_W'(3);
  localparam logic [N_W-1:0]   N_HI  = N_W'(8);
  localparam logic [M1_W-1:0]  M1_LO = M1_W'(10);
  localparam logic [M1_W-1:0]  M1_HI = M1_W'(20);
  localparam logic [M2_W-1:0]  M2_LO = M2_W'(5);
  localparam logic [M2_W-1:0]  M2_HI = M2_W'(9);
  localparam logic [P1_W-1:0]  P1_LO = P1_W'(1);
  localparam logic [P1_W-1:0]  P1_HI = P1_W'(8);
  localparam logic [DEN_W-1:0] P2_FIX = DEN_W'(10);
  localparam logic [M_W-1:0]   M_LO  = M_W'(70);
  localparam logic [M_W-1:0]   M_HI  = M_W'(120);
  localparam logic [DEN_W-1:0] P_LO  = DEN_W'(5);
  localparam logic [DEN_W-1:0] P_HI  = DEN_W'(80);
  localparam logic [NUM_W-1:0] VCO_LO = NUM_W'(1400000);
  localparam logic [NUM_W-1:0] VCO_HI = NUM_W'(2800000);
  localparam logic [NUM_W-1:0] DOT_LO = NUM_W'(20000);
  localparam logic [NUM_W-1:0] DOT_HI = NUM_W'(400000);
  localparam logic [PIX_W-1:0] PIX_MIN = PIX_W'(25000);
  localparam logic [PIX_W-1:0] PIX_MID = PIX_W'(50000);
  localparam logic [PIX_W-1:0] PIX_TOP = PIX_W'(100000);

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic stepP1;
    logic stepOuter;
    logic startVco;
    logic latchVco;
    logic startDot;
    logic keepBest;
    logic commit;
    logic commitExact;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pixOk;
    logic outerOk;
    logic lastP1;
    logic lastOuter;
    logic divDone;
    logic vcoOk;
    logic dotOk;
    logic dotExact;
    logic dotBetter;
  } flag_t;

  function automatic logic [WORD_W-1:0] packDiv(input logic [N_W-1:0] n,
                                                 input logic [M1_W-1:0] m1,
                                                 input logic [M2_W-1:0] m2);
    return {FIELD_W'(n) - FIELD_W'(2), FIELD_W'(m1) - FIELD_W'(2), FIELD_W'(m2) - FIELD_W'(2)};
  endfunction
endpackage

// File: rtl/pll_search_div.sv
`timescale 1ns/1ps
module pll_search_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 8,
  parameter int STEPS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem
);
  localparam int ITER  = NUM_W / STEPS;
  localparam int CNT_W = $clog2(ITER + 1);
  localparam int PW    = NUM_W + DEN_W;

  logic [CNT_W-1:0] cnt;
  logic [DEN_W-1:0] denReg;
  logic [NUM_W-1:0] numReg;
  logic [NUM_W-1:0] qNext;
  logic [DEN_W-1:0] rNext;
  logic [DEN_W:0]   sh;

  // STEPS restoring stages per cycle
  always_comb begin
    qNext = quo;
    rNext = rem;
    sh    = '0;
    for (int i = 0; i < STEPS; i++) begin
      sh    = {rNext, qNext[NUM_W-1]};
      qNext = {qNext[NUM_W-2:0], 1'b0};
      if (sh >= {1'b0, denReg}) begin
        rNext    = DEN_W'(sh - {1'b0, denReg});
        qNext[0] = 1'b1;
      end else begin
        rNext = sh[DEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      denReg <= DEN_W'(1);
      numReg <= '0;
      quo    <= '0;
      rem    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        numReg <= num;
        denReg <= den;
        quo    <= num;
        rem    <= '0;
        cnt    <= CNT_W'(ITER);
      end else if (cnt != '0) begin
        quo <= qNext;
        rem <= rNext;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  // R3: the quotient and remainder satisfy the division identity
  a_r3_div_identity: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (PW'(quo) * PW'(denReg) + PW'(rem) == PW'(numReg)) && (rem < denReg));
  a_r3_nonzero_den: assert property (@(posedge clk) disable iff (!rstN)
    start |-> den != '0);
endmodule

// File: rtl/pll_search_ctl.sv
`timescale 1ns/1ps
module pll_search_ctl
  import pll_search_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  flag_t   fl,
  output strobe_t st,
  output logic    busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_OUTER, S_VCOWAIT, S_DOT, S_DOTWAIT, S_FIN
  } state_t;

  state_t state, nxt;

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin st.load = 1'b1; nxt = S_SETUP; end
      S_SETUP: nxt = fl.pixOk ? S_OUTER : S_FIN;
      S_OUTER: begin
        if (fl.outerOk) begin st.startVco = 1'b1; nxt = S_VCOWAIT; end
        else if (fl.lastOuter) nxt = S_FIN;
        else st.stepOuter = 1'b1;
      end
      S_VCOWAIT: if (fl.divDone) begin
        if (fl.vcoOk) begin st.latchVco = 1'b1; nxt = S_DOT; end
        else if (fl.lastOuter) nxt = S_FIN;
        else begin st.stepOuter = 1'b1; nxt = S_OUTER; end
      end
      S_DOT: begin st.startDot = 1'b1; nxt = S_DOTWAIT; end
      S_DOTWAIT: if (fl.divDone) begin
        if (fl.dotOk && fl.dotExact) begin
          st.commitExact = 1'b1;
          nxt = S_IDLE;
        end else begin
          st.keepBest = fl.dotOk && fl.dotBetter;
          if (!fl.lastP1) begin st.stepP1 = 1'b1; nxt = S_DOT; end
          else if (fl.lastOuter) nxt = S_FIN;
          else begin st.stepOuter = 1'b1; nxt = S_OUTER; end
        end
      end
      S_FIN: begin st.commit = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  // R11: a start seen while busy never reloads the search
  a_r11_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !st.load);
  // R6: an exact hit never coincides with keeping an overshoot
  a_r6_exact_alone: assert property (@(posedge clk) disable iff (!rstN)
    st.commitExact |-> !st.keepBest && !st.stepP1 && !st.stepOuter);
endmodule

// File: rtl/pll_search_dp.sv
`timescale 1ns/1ps
module pll_search_dp
  import pll_search_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [PIX_W-1:0]  pixKhz,
  input  logic [REF_W-1:0]  refKhz,
  output flag_t             fl,
  output logic              done,
  output logic              found,
  output logic [N_W-1:0]    nOut,
  output logic [M1_W-1:0]   m1Out,
  output logic [M2_W-1:0]   m2Out,
  output logic [P1_W-1:0]   p1Out,
  output logic [MULT_W-1:0] dacMult,
  output logic [WORD_W-1:0] divWord
);
  logic [N_W-1:0]    nCnt, bestN;
  logic [M1_W-1:0]   m1Cnt, bestM1;
  logic [M2_W-1:0]   m2Cnt, bestM2;
  logic [P1_W-1:0]   p1Cnt, bestP1;
  logic [NUM_W-1:0]  targetReg, vcoReg, bestErr;
  logic [REF_W-1:0]  refReg;
  logic [MULT_W-1:0] multReg, multIn;
  logic              pixOkReg, bestValid;
  logic [M_W-1:0]    mVal;
  logic [DEN_W-1:0]  pVal;
  logic              divDone;
  logic [NUM_W-1:0]  quo;
  logic [DEN_W-1:0]  rem;
  logic [NUM_W-1:0]  divNum;
  logic [DEN_W-1:0]  divDen;

  always_comb begin
    if (pixKhz >= PIX_TOP)      multIn = MULT_W'(1);
    else if (pixKhz >= PIX_MID) multIn = MULT_W'(2);
    else if (pixKhz >= PIX_MIN) multIn = MULT_W'(4);
    else                        multIn = '0;
  end

  assign mVal   = M_W'(m1Cnt) * M_W'(5) + M_W'(m2Cnt);
  assign pVal   = DEN_W'(p1Cnt) * P2_FIX;
  assign divNum = st.startVco ? NUM_W'(refReg) * NUM_W'(mVal) : vcoReg;
  assign divDen = st.startVco ? DEN_W'(nCnt) : pVal;

  pll_search_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .STEPS(STEPS)) uDiv (
    .clk(clk), .rstN(rstN), .start(st.startVco | st.startDot),
    .num(divNum), .den(divDen), .done(divDone), .quo(quo), .rem(rem)
  );

  always_comb begin
    fl.pixOk     = pixOkReg;
    fl.outerOk   = (mVal >= M_LO) && (mVal <= M_HI) && (m1Cnt > M1_W'(m2Cnt));
    fl.lastP1    = (p1Cnt == P1_LO);
    fl.lastOuter = (nCnt == N_HI) && (m1Cnt == M1_LO) && (m2Cnt == M2_LO);
    fl.divDone   = divDone;
    fl.vcoOk     = (quo >= VCO_LO) && (quo <= VCO_HI);
    fl.dotOk     = (quo >= DOT_LO) && (quo <= DOT_HI) && (pVal >= P_LO) && (pVal <= P_HI);
    fl.dotExact  = (quo == targetReg);
    fl.dotBetter = (quo > targetReg) && (!bestValid || ((quo - targetReg) < bestErr));
  end

  // candidate counters: n up, m1 down, m2 down, p1 down (innermost)
  always_ff @(posedge clk) begin
    if (!rstN || st.load) begin
      nCnt  <= N_LO;
      m1Cnt <= M1_HI;
      m2Cnt <= M2_HI;
      p1Cnt <= P1_HI;
    end else if (st.stepP1) begin
      p1Cnt <= p1Cnt - 1'b1;
    end else if (st.stepOuter) begin
      p1Cnt <= P1_HI;
      if (m2Cnt != M2_LO) m2Cnt <= m2Cnt - 1'b1;
      else begin
        m2Cnt <= M2_HI;
        if (m1Cnt != M1_LO) m1Cnt <= m1Cnt - 1'b1;
        else begin
          m1Cnt <= M1_HI;
          nCnt  <= nCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetReg <= '0; refReg <= '0; multReg <= '0; pixOkReg <= 1'b0;
      vcoReg <= '0; bestValid <= 1'b0; bestErr <= '0;
      bestN <= '0; bestM1 <= '0; bestM2 <= '0; bestP1 <= '0;
      done <= 1'b0; found <= 1'b0; nOut <= '0; m1Out <= '0; m2Out <= '0;
      p1Out <= '0; dacMult <= '0; divWord <= '0;
    end else begin
      done <= st.commit | st.commitExact;
      if (st.load) begin
        targetReg <= NUM_W'(pixKhz) * NUM_W'(multIn);
        refReg    <= refKhz;
        multReg   <= multIn;
        pixOkReg  <= (multIn != '0);
        bestValid <= 1'b0;
        bestErr   <= '0;
      end
      if (st.latchVco) vcoReg <= quo;
      if (st.keepBest) begin
        bestValid <= 1'b1;
        bestErr   <= quo - targetReg;
        bestN <= nCnt; bestM1 <= m1Cnt; bestM2 <= m2Cnt; bestP1 <= p1Cnt;
      end
      if (st.commitExact) begin
        found <= 1'b1; dacMult <= multReg;
        nOut <= nCnt; m1Out <= m1Cnt; m2Out <= m2Cnt; p1Out <= p1Cnt;
        divWord <= packDiv(nCnt, m1Cnt, m2Cnt);
      end else if (st.commit) begin
        found <= bestValid; dacMult <= multReg;
        if (bestValid) begin
          nOut <= bestN; m1Out <= bestM1; m2Out <= bestM2; p1Out <= bestP1;
          divWord <= packDiv(bestN, bestM1, bestM2);
        end else begin
          nOut <= '0; m1Out <= '0; m2Out <= '0; p1Out <= '0; divWord <= '0;
        end
      end
    end
  end

  // R7: only a dot clock above the target can be kept
  a_r7_overshoot_only: assert property (@(posedge clk) disable iff (!rstN)
    st.keepBest |-> quo > targetReg);
  // R6: an exact commit carries a quotient equal to the target
  a_r6_exact_match: assert property (@(posedge clk) disable iff (!rstN)
    st.commitExact |-> quo == targetReg);
  // R4: a kept candidate satisfies the feedback rules
  a_r4_legal_keep: assert property (@(posedge clk) disable iff (!rstN)
    st.keepBest |-> (mVal >= M_LO) && (mVal <= M_HI) && (m1Cnt > M1_W'(m2Cnt)));
  // R5: counters never leave their ranges while walking
  a_r5_counter_range: assert property (@(posedge clk) disable iff (!rstN)
    (nCnt >= N_LO) && (nCnt <= N_HI) && (m1Cnt >= M1_LO) && (m1Cnt <= M1_HI) &&
    (m2Cnt >= M2_LO) && (m2Cnt <= M2_HI) && (p1Cnt >= P1_LO) && (p1Cnt <= P1_HI));
endmodule

// File: rtl/pll_search.sv
`timescale 1ns/1ps
module pll_search
  import pll_search_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PIX_W-1:0]  pixKhz,
  input  logic [REF_W-1:0]  refKhz,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [N_W-1:0]    nOut,
  output logic [M1_W-1:0]   m1Out,
  output logic [M2_W-1:0]   m2Out,
  output logic [P1_W-1:0]   p1Out,
  output logic [MULT_W-1:0] dacMult,
  output logic [WORD_W-1:0] divWord
);
  strobe_t st;
  flag_t   fl;

  pll_search_ctl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .fl(fl), .st(st), .busy(busy)
  );

  pll_search_dp #(.STEPS(STEPS)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .pixKhz(pixKhz), .refKhz(refKhz), .fl(fl),
    .done(done), .found(found), .nOut(nOut), .m1Out(m1Out), .m2Out(m2Out),
    .p1Out(p1Out), .dacMult(dacMult), .divWord(divWord)
  );

  // R10: single-cycle done, aligned with busy falling, results held otherwise
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_busy_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({found, nOut, m1Out, m2Out, p1Out, dacMult, divWord}) |-> done);
  // R2: a found result always carries a nonzero multiplier
  a_r2_mult_set: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> dacMult != '0);
endmodule

// File: tb/tb_pll_search.sv
`timescale 1ns/1ps
module tb_pll_search;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pixKhz = '0;
  logic [16:0] refKhz = '0;
  logic        busy, done, found;
  logic [3:0]  nOut, m2Out, p1Out;
  logic [4:0]  m1Out;
  logic [2:0]  dacMult;
  logic [23:0] divWord;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_search dut (
    .clk(clk), .rstN(rstN), .start(start), .pixKhz(pixKhz), .refKhz(refKhz),
    .busy(busy), .done(done), .found(found), .nOut(nOut), .m1Out(m1Out),
    .m2Out(m2Out), .p1Out(p1Out), .dacMult(dacMult), .divWord(divWord)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // arithmetic model of the whole search
  function automatic void model(input longint pix, input longint rf,
                                output bit fnd, output bit exact,
                                output longint en, output longint em1,
                                output longint em2, output longint ep1,
                                output longint emult);
    longint tgt, be, m, vco, dot;
    bit bv;
    fnd = 0; exact = 0; en = 0; em1 = 0; em2 = 0; ep1 = 0; bv = 0; be = 0;
    if (pix >= 100000) emult = 1;
    else if (pix >= 50000) emult = 2;
    else if (pix >= 25000) emult = 4;
    else begin emult = 0; return; end
    tgt = pix * emult;
    for (int n = 3; n <= 8; n++)
      for (int m1 = 20; m1 >= 10; m1--)
        for (int m2 = 9; m2 >= 5; m2--)
          for (int p1 = 8; p1 >= 1; p1--) begin
            m = 5 * m1 + m2;
            if (m < 70 || m > 120 || m1 <= m2) continue;
            if (p1 * 10 < 5 || p1 * 10 > 80) continue;
            vco = rf * m / n;
            if (vco < 1400000 || vco > 2800000) continue;
            dot = vco / (p1 * 10);
            if (dot < 20000 || dot > 400000) continue;
            if (dot == tgt) begin
              fnd = 1; exact = 1; en = n; em1 = m1; em2 = m2; ep1 = p1;
              return;
            end
            if (dot > tgt && (!bv || dot - tgt < be)) begin
              bv = 1; be = dot - tgt; en = n; em1 = m1; em2 = m2; ep1 = p1;
            end
          end
    fnd = bv;
  endfunction

  task automatic pulseStart(input longint pix, input longint rf);
    @(negedge clk);
    pixKhz = 20'(pix); refKhz = 17'(rf); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 1;
    while (!done) begin @(negedge clk); cyc++; end
  endtask

  task automatic compare(input longint pix, input longint rf);
    bit fnd, ex;
    longint en, em1, em2, ep1, emult, word, dotAct;
    model(pix, rf, fnd, ex, en, em1, em2, ep1, emult);
    check($sformatf("R2 mult pix=%0d", pix), dacMult, emult);
    check($sformatf("R7 R8 found pix=%0d", pix), found, fnd);
    check($sformatf("R4 R5 R7 n pix=%0d", pix), nOut, en);
    check($sformatf("R4 R5 R7 m1 pix=%0d", pix), m1Out, em1);
    check($sformatf("R4 R5 R7 m2 pix=%0d", pix), m2Out, em2);
    check($sformatf("R3 R5 R7 p1 pix=%0d", pix), p1Out, ep1);
    word = fnd ? (((en - 2) << 16) | ((em1 - 2) << 8) | (em2 - 2)) : 0;
    check($sformatf("R9 word pix=%0d", pix), divWord, word);
    check($sformatf("R10 busy low at done pix=%0d", pix), busy, 0);
    if (ex) begin
      dotAct = (rf * (5 * longint'(m1Out) + longint'(m2Out)) / longint'(nOut)) / (10 * longint'(p1Out));
      check($sformatf("R6 exact dot pix=%0d", pix), dotAct, pix * emult);
    end
    @(negedge clk);
    check($sformatf("R10 done pulse pix=%0d", pix), done, 0);
  endtask

  task automatic runOne(input longint pix, input longint rf);
    int cyc;
    pulseStart(pix, rf);
    waitDone(cyc);
    compare(pix, rf);
  endtask

  initial begin
    int cyc;
    logic [23:0] heldWord;
    logic [3:0]  heldN;
    repeat (4) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 found", found, 0);
    check("R1 word", divWord, 0);
    check("R1 mult", dacMult, 0);
    rstN = 1'b1;
    @(negedge clk);

    // below the minimum pixel clock: quick not-found
    pulseStart(24999, 96000);
    waitDone(cyc);
    check("R2 early finish", (cyc <= 4) ? 1 : 0, 1);
    compare(24999, 96000);

    runOne(25000, 96000);
    runOne(49999, 96000);
    runOne(50000, 96000);
    runOne(96000, 96000);
    runOne(99999, 96000);
    runOne(100000, 96000);
    runOne(148500, 96000);
    runOne(400001, 96000);   // R8 exhaustion with no overshoot
    runOne(65000, 100000);

    // R10 hold: inputs change without start, outputs stay
    heldWord = divWord; heldN = nOut;
    pixKhz = 20'd30000; refKhz = 17'd90000;
    repeat (8) @(negedge clk);
    check("R10 hold word", divWord, heldWord);
    check("R10 hold n", nOut, heldN);
    check("R10 idle busy", busy, 0);

    // R11: start during a search is ignored
    pulseStart(74250, 96000);
    repeat (20) @(negedge clk);
    check("R11 busy mid search", busy, 1);
    pixKhz = 20'd30000; refKhz = 17'd90000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(cyc);
    compare(74250, 96000);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog R10 actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule